// File: doc/BRIEF.md
# Search Triplet Step Sequencer

This block carries out one branch decision of a single-wire device-identifier search. After a start strobe it asks a bit-slot engine for two read slots. The first slot returns the identifier bit that all devices still taking part put on the wire. The second slot returns the complement of that bit. From the pair the block chooses a branch direction and then asks for one write slot that carries that direction, so that devices on the other branch drop out. A pair of ones means no device answered, so the block reports an error code and skips the write slot.

The caller gives a preferred direction. That preference matters only when both read bits are zero, which means devices disagree at this bit position. The block returns a packed 3-bit result and a one-cycle done pulse. The enclosing loop over identifier bits and the tracking of discrepancy positions belong to the caller. Each slot goes to the engine through a request/acknowledge pair: a request with its slot kind and write value is held until the engine acknowledges it, and on a read the acknowledge comes with the sampled wire level.

Top module: `srch_step_seq`

## Requirements
- R1: After reset, slot_req, done, busy and result (3'b000) are all low.
- R2: A step starts with exactly two read slots in order (slot_wr=0, slot_wbit=1). The level returned by the first is the identifier bit and the level returned by the second is its complement bit.
- R3: The result packs the identifier bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2.
- R4: When both read bits are 1 the result is 3'b011, and no write slot is requested for that step.
- R5: When both read bits are 0 the direction is pref_dir as sampled on the cycle go is accepted, giving 3'b100 for 1 and 3'b000 for 0. Later changes of pref_dir have no effect on that step.
- R6: When exactly one read bit is 1 the direction equals the identifier bit, giving 3'b101 for id=1 and 3'b010 for id=0.
- R7: Unless the step aborted, after the second read the block requests exactly one write slot (slot_wr=1) with slot_wbit equal to the direction taken.
- R8: done is high for exactly one cycle. It rises after the write slot is acknowledged, or after the second read is acknowledged when the step aborts. result is valid with done and is held until the next done.
- R9: Once slot_req is raised it stays high, with slot_wr and slot_wbit unchanged, until a cycle in which slot_ack is high. It is low on the following cycle.
- R10: busy is high from the cycle after go is accepted until done. go is ignored while busy is high, and starts no extra slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe for one search step |
| pref_dir | input | 1 | Direction to take when devices disagree |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 3 | {direction, complement bit, identifier bit} |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_wr | output | 1 | Slot kind: 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Level driven in the slot (1 for reads) |
| slot_ack | input | 1 | Engine finished the requested slot |
| slot_rbit | input | 1 | Wire level sampled in a read slot, valid with slot_ack |

## Verification
The two conditions hardest to reach from the ports are a start strobe that arrives in the middle of a step and a preference that changes after the step has begun. Both can corrupt a step without any visible glitch in the result code. The bench pulses go again while the slot engine is still busy and flips pref_dir right after the start. Afterwards it counts the slots the engine actually served and compares the direction against the preference held at the start. The stub engine acknowledges after a random latency and plays back scripted bit pairs, so every read-pair combination occurs under varied handshake timing.

// File: rtl/srch_pkg.sv
package srch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WT_ID,
    ST_ISS_CMP,
    ST_WT_CMP,
    ST_ISS_DIR,
    ST_WT_DIR
  } srch_state_t;

  localparam logic SLOT_READ  = 1'b0;
  localparam logic SLOT_WRITE = 1'b1;

  // code returned when no device answered either read slot
  localparam logic [2:0] CODE_ABORT = 3'b011;

endpackage

// File: rtl/srch_slot_port.sv
module srch_slot_port (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic launch_wr,
  input  logic launch_bit,
  input  logic slot_ack,
  output logic slot_req,
  output logic slot_wr,
  output logic slot_wbit,
  output logic slot_taken
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_req  <= 1'b0;
      slot_wr   <= 1'b0;
      slot_wbit <= 1'b0;
    end else if (launch) begin
      slot_req  <= 1'b1;
      slot_wr   <= launch_wr;
      slot_wbit <= launch_bit;
    end else if (slot_req && slot_ack) begin
      slot_req  <= 1'b0;
    end
  end

  assign slot_taken = slot_req && slot_ack;

  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wr) && $stable(slot_wbit)))
    else $error("request dropped or changed before acknowledge");

  p_req_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_ack) |=> !slot_req)
    else $error("request still high after acknowledge");

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    launch |-> !slot_req)
    else $error("new slot launched over a pending one");

endmodule

// File: rtl/srch_resolve.sv
module srch_resolve (
  input  logic id_bit,
  input  logic cmp_bit,
  input  logic pref,
  output logic abort,
  output logic dir
);

  always_comb begin
    abort = id_bit && cmp_bit;
    if (id_bit ^ cmp_bit) dir = id_bit;
    else                  dir = pref;
  end

endmodule

// File: rtl/srch_step_ctrl.sv
module srch_step_ctrl
  import srch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       pref_dir,
  input  logic       slot_taken,
  input  logic       slot_rbit,
  input  logic       abort,
  input  logic       dir,
  output logic       id_q,
  output logic       pref_q,
  output logic       launch,
  output logic       launch_wr,
  output logic       launch_bit,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);

  srch_state_t state;
  logic        cmp_q;
  logic        dir_q;

  always_comb begin
    launch     = (state == ST_IDLE && go) || state == ST_ISS_CMP || state == ST_ISS_DIR;
    launch_wr  = (state == ST_ISS_DIR) ? SLOT_WRITE : SLOT_READ;
    launch_bit = (state == ST_ISS_DIR) ? dir_q : 1'b1;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      dir_q  <= 1'b0;
      pref_q <= 1'b0;
      done   <= 1'b0;
      result <= 3'b000;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            pref_q <= pref_dir;
            state  <= ST_WT_ID;
          end
        end
        ST_WT_ID: begin
          if (slot_taken) begin
            id_q  <= slot_rbit;
            state <= ST_ISS_CMP;
          end
        end
        ST_ISS_CMP: state <= ST_WT_CMP;
        ST_WT_CMP: begin
          if (slot_taken) begin
            cmp_q <= slot_rbit;
            if (abort) begin
              result <= CODE_ABORT;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              dir_q <= dir;
              state <= ST_ISS_DIR;
            end
          end
        end
        ST_ISS_DIR: state <= ST_WT_DIR;
        ST_WT_DIR: begin
          if (slot_taken) begin
            result <= {dir_q, cmp_q, id_q};
            done   <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done longer than one cycle");

  p_abort_code_r4: assert property (@(posedge clk) disable iff (rst)
    (done && result[0] && result[1]) |-> !result[2])
    else $error("abort code carries a direction");

  p_single_dir_r6: assert property (@(posedge clk) disable iff (rst)
    (done && (result[0] ^ result[1])) |-> (result[2] == result[0]))
    else $error("direction differs from identifier bit");

  p_no_write_abort_r4: assert property (@(posedge clk) disable iff (rst)
    (launch && launch_wr) |-> !(id_q && cmp_q))
    else $error("write slot launched after abort");

  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |=> busy)
    else $error("accepted go did not raise busy");

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result) || done)
    else $error("result changed without done");

endmodule

// File: rtl/srch_step_seq.sv
module srch_step_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       pref_dir,
  output logic       busy,
  output logic       done,
  output logic [2:0] result,
  output logic       slot_req,
  output logic       slot_wr,
  output logic       slot_wbit,
  input  logic       slot_ack,
  input  logic       slot_rbit
);

  logic launch, launch_wr, launch_bit, slot_taken;
  logic id_q, pref_q, abort, dir;

  srch_step_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .pref_dir   (pref_dir),
    .slot_taken (slot_taken),
    .slot_rbit  (slot_rbit),
    .abort      (abort),
    .dir        (dir),
    .id_q       (id_q),
    .pref_q     (pref_q),
    .launch     (launch),
    .launch_wr  (launch_wr),
    .launch_bit (launch_bit),
    .busy       (busy),
    .done       (done),
    .result     (result)
  );

  // complement bit is resolved live on the acknowledge of the second read
  srch_resolve u_res (
    .id_bit  (id_q),
    .cmp_bit (slot_rbit),
    .pref    (pref_q),
    .abort   (abort),
    .dir     (dir)
  );

  srch_slot_port u_port (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_wr  (launch_wr),
    .launch_bit (launch_bit),
    .slot_ack   (slot_ack),
    .slot_req   (slot_req),
    .slot_wr    (slot_wr),
    .slot_wbit  (slot_wbit),
    .slot_taken (slot_taken)
  );

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> !slot_req || $past(slot_req))
    else $error("slot requested while idle");

endmodule

// File: tb/sim_srch_step_seq.sv
`timescale 1ns/1ps
module sim_srch_step_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0, pref_dir = 1'b0;
  logic busy, done, slot_req, slot_wr, slot_wbit;
  logic slot_ack = 1'b0, slot_rbit = 1'b0;
  logic [2:0] result;

  int n_chk = 0, n_bad = 0;
  bit rd_bits [2];
  int nslot = 0, lat = 0;
  bit log_wr [8];
  bit log_wb [8];

  always #5 clk = ~clk;

  srch_step_seq u0 (
    .clk(clk), .rst(rst), .go(go), .pref_dir(pref_dir),
    .busy(busy), .done(done), .result(result),
    .slot_req(slot_req), .slot_wr(slot_wr), .slot_wbit(slot_wbit),
    .slot_ack(slot_ack), .slot_rbit(slot_rbit)
  );

  // stub slot engine: random latency, scripted read levels
  always @(negedge clk) begin
    if (rst) begin
      slot_ack = 1'b0;
    end else if (slot_ack) begin
      slot_ack = 1'b0;
    end else if (slot_req) begin
      if (lat == 0) begin
        slot_ack  = 1'b1;
        slot_rbit = (nslot < 2) ? rd_bits[nslot] : 1'($urandom);
        if (nslot < 8) begin
          log_wr[nslot] = slot_wr;
          log_wb[nslot] = slot_wbit;
        end
        nslot++;
        lat = $urandom % 4;
      end else begin
        lat--;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(bit id, bit cmp, bit pref);
    if (id && cmp)        return 3'b011;
    else if (!id && !cmp) return pref ? 3'b100 : 3'b000;
    else                  return id ? 3'b101 : 3'b010;
  endfunction

  task automatic run_step(bit id, bit cmp, bit pref, bit flip, bit extra_go);
    logic [2:0] exp = exp_code(id, cmp, pref);
    int n = 0;
    int exp_slots = (id && cmp) ? 2 : 3;
    nslot = 0;
    rd_bits[0] = id;
    rd_bits[1] = cmp;
    @(negedge clk);
    pref_dir = pref;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(busy == 1'b1, "R10 busy after go", int'(busy), 1);
    if (flip) pref_dir = ~pref;
    while (!done && n < 200) begin
      if (extra_go && n == 2) go = 1'b1;
      else go = 1'b0;
      @(negedge clk);
      n++;
    end
    go = 1'b0;
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(result == exp, (id && cmp) ? "R4 abort code" :
          (id == cmp) ? "R5 preference code" : "R6 single-bit code",
          int'(result), int'(exp));
    check(result[0] == id && result[1] == cmp, "R3 packed bits", int'(result[1:0]), int'({cmp, id}));
    check(busy == 1'b0, "R10 idle at done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    repeat (6) @(negedge clk);
    check(nslot == exp_slots, (id && cmp) ? "R4 no write slot" : "R7 slot count",
          nslot, exp_slots);
    check(!log_wr[0] && !log_wr[1] && log_wb[0] && log_wb[1], "R2 two read slots",
          int'({log_wr[0], log_wr[1], log_wb[0], log_wb[1]}), 3);
    if (exp_slots == 3)
      check(log_wr[2] && log_wb[2] == exp[2], "R7 write slot value",
            int'({log_wr[2], log_wb[2]}), int'({1'b1, exp[2]}));
    check(result == exp && slot_req == 1'b0, "R8 result held, R9 no stray request",
          int'({slot_req, result}), int'(exp));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({slot_req, done, busy, result} == 6'd0, "R1 reset state",
          int'({slot_req, done, busy, result}), 0);
    for (int c = 0; c < 8; c++)
      run_step(c[0], c[1], c[2], 1'b0, 1'b0);
    // preference changed after start, go pulsed while busy
    run_step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 40; k++)
      run_step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule